// File: doc/BRIEF.md
# Dual-Port Latch Register File

A small storage array of four words, four bits wide, with separate write and read address paths. One word can be written while another is read at the same moment. The block has no clock. Each word is a bank of level-sensitive latches. A latch bank is open while the active-low write strobe is low and its address is selected. While a latch is open, the incoming data passes straight through to the stored value and on to any read of that word.

The read side drives a data bus together with an output-enable flag. When the active-low read strobe is high, the flag is low and the data bus is forced to zero. Several instances can therefore share one bus for depth expansion, either through a tri-state driver at integration or by OR-ing the outputs. Width expansion places instances side by side on common address and strobe lines. Stored contents are undefined after power-up until each word has been written.

The ports are plain control pins. No valid/ready handshake applies, because a write lands whenever the strobe is low and a read is a continuous combinational view, so there is nothing to back-pressure.

Top module: `rfl_regfile`

## Requirements
- R1: While `wr_en_n` is 0, the word whose index equals `wr_addr` (value n selects word n) takes `wr_data`, and no other word changes.
- R2: While `wr_en_n` is 1, `wr_data` and `wr_addr` have no effect and every stored word keeps its value.
- R3: While a word is open for write, each change of `wr_data` reaches that word in the same cycle. The value present when `wr_en_n` rises is the value retained.
- R4: While `rd_en_n` is 1, `rd_oe` is 0 and `rd_q` is all zeros.
- R5: While `rd_en_n` is 0, `rd_oe` is 1 and `rd_q` equals the word indexed by `rd_addr`, uninverted.
- R6: Writing one word while reading a different word leaves the read value equal to the read word's stored contents.
- R7: Reading is non-destructive: repeated reads of a word return the same value.
- R8: When `wr_en_n` and `rd_en_n` are both 0 and `wr_addr` equals `rd_addr`, `rd_q` equals `wr_data` (write-through).
- R9: Two instances sharing address and data lines, with only one read strobe low, give exactly one asserted `rd_oe`, and the combined bus carries the enabled instance's word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_data | input | 4 | Data to store |
| wr_addr | input | 2 | Write word index |
| wr_en_n | input | 1 | Write strobe, active low; opens the addressed latches |
| rd_addr | input | 2 | Read word index |
| rd_en_n | input | 1 | Read strobe, active low |
| rd_q | output | 4 | Read data, zero while not enabled |
| rd_oe | output | 1 | Output enable for a tri-state bus driver |

## Verification
Every result of this block is combinational, so each one is due zero cycles after its stimulus: no register lies between any input and `rd_q` or `rd_oe`. The bench changes inputs on the falling clock edge and samples 1 ns later, well inside the same half-period. Stored values are checked by reading them back after the write strobe has been raised. Every word is written before any stored value is compared.

// File: rtl/rfl_pkg.sv
package rfl_pkg;
  localparam int unsigned RFL_WORDS = 4;
  localparam int unsigned RFL_WIDTH = 4;
endpackage

// File: rtl/rfl_wr_decode.sv
module rfl_wr_decode #(
  parameter int unsigned WORDS = rfl_pkg::RFL_WORDS,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [AW-1:0]    addr,
  input  logic             en_n,
  output logic [WORDS-1:0] sel
);
  for (genvar w = 0; w < WORDS; w++) begin : g_term
    // address match term AND strobe term
    assign sel[w] = (addr == AW'(w)) && !en_n;
  end
endmodule

// File: rtl/rfl_latch_word.sv
module rfl_latch_word #(
  parameter int unsigned WIDTH = rfl_pkg::RFL_WIDTH
) (
  input  logic             open_i,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_latch begin
    if (open_i) q <= d;
  end
endmodule

// File: rtl/rfl_rd_mux.sv
module rfl_rd_mux #(
  parameter int unsigned WORDS = rfl_pkg::RFL_WORDS,
  parameter int unsigned WIDTH = rfl_pkg::RFL_WIDTH,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [WORDS-1:0][WIDTH-1:0] words,
  input  logic [AW-1:0]               addr,
  input  logic                        en_n,
  output logic [WIDTH-1:0]            q,
  output logic                        oe
);
  always_comb begin
    q  = '0;
    oe = 1'b0;
    if (!en_n) begin
      q  = words[addr];
      oe = 1'b1;
    end
  end
endmodule

// File: rtl/rfl_regfile.sv
module rfl_regfile #(
  parameter int unsigned WORDS = rfl_pkg::RFL_WORDS,
  parameter int unsigned WIDTH = rfl_pkg::RFL_WIDTH,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    wr_addr,
  input  logic             wr_en_n,
  input  logic [AW-1:0]    rd_addr,
  input  logic             rd_en_n,
  output logic [WIDTH-1:0] rd_q,
  output logic             rd_oe
);
  logic [WORDS-1:0]            wr_sel;
  logic [WORDS-1:0][WIDTH-1:0] words;

  rfl_wr_decode #(.WORDS(WORDS)) u_dec (
    .addr (wr_addr),
    .en_n (wr_en_n),
    .sel  (wr_sel)
  );

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    rfl_latch_word #(.WIDTH(WIDTH)) u_word (
      .open_i (wr_sel[w]),
      .d      (wr_data),
      .q      (words[w])
    );
  end

  rfl_rd_mux #(.WORDS(WORDS), .WIDTH(WIDTH)) u_rd (
    .words (words),
    .addr  (rd_addr),
    .en_n  (rd_en_n),
    .q     (rd_q),
    .oe    (rd_oe)
  );
endmodule

// File: rtl/rfl_regfile_chk.sv
module rfl_regfile_chk #(
  parameter int unsigned WORDS = rfl_pkg::RFL_WORDS,
  parameter int unsigned WIDTH = rfl_pkg::RFL_WIDTH,
  localparam int unsigned AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input logic [WIDTH-1:0]            wr_data,
  input logic [AW-1:0]               wr_addr,
  input logic                        wr_en_n,
  input logic [AW-1:0]               rd_addr,
  input logic                        rd_en_n,
  input logic [WIDTH-1:0]            rd_q,
  input logic                        rd_oe,
  input logic [WORDS-1:0]            wr_sel,
  input logic [WORDS-1:0][WIDTH-1:0] words
);
  always_comb begin
    AST_SEL_ONEHOT: assert ($onehot0(wr_sel)) else $error("write select not one-hot"); // R1
    if (wr_en_n) begin
      AST_NO_SEL_IDLE: assert (wr_sel == '0) else $error("word open while strobe high"); // R2
    end
    if (!wr_en_n) begin
      AST_OPEN_FOLLOWS: assert (words[wr_addr] == wr_data) else $error("open word lags data"); // R3
    end
    if (rd_en_n) begin
      AST_OUT_IDLE: assert (!rd_oe && rd_q == '0) else $error("output active while read off"); // R4
    end
    if (!rd_en_n) begin
      AST_READ_WORD: assert (rd_oe && rd_q == words[rd_addr]) else $error("read data mismatch"); // R5
    end
    if (!wr_en_n && !rd_en_n && wr_addr == rd_addr) begin
      AST_WRITE_THROUGH: assert (rd_q == wr_data) else $error("write-through missing"); // R8
    end
  end
endmodule

bind rfl_regfile rfl_regfile_chk #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
  .wr_data (wr_data),
  .wr_addr (wr_addr),
  .wr_en_n (wr_en_n),
  .rd_addr (rd_addr),
  .rd_en_n (rd_en_n),
  .rd_q    (rd_q),
  .rd_oe   (rd_oe),
  .wr_sel  (wr_sel),
  .words   (words)
);

// File: tb/rfl_regfile_tb_top.sv
`timescale 1ns/1ps
module rfl_regfile_tb_top;
  logic       clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] wr_data = '0;
  logic [1:0] wr_addr = '0;
  logic       wr_en_n = 1'b1;
  logic       wr_en_b_n = 1'b1;
  logic [1:0] rd_addr = '0;
  logic       rd_en_n = 1'b1;
  logic       rd_en_b_n = 1'b1;
  logic [3:0] rd_q, rd_q_b;
  logic       rd_oe, rd_oe_b;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [3:0] model [4];

  rfl_regfile dut_i (
    .wr_data(wr_data), .wr_addr(wr_addr), .wr_en_n(wr_en_n),
    .rd_addr(rd_addr), .rd_en_n(rd_en_n), .rd_q(rd_q), .rd_oe(rd_oe));

  rfl_regfile dut_b (
    .wr_data(wr_data), .wr_addr(wr_addr), .wr_en_n(wr_en_b_n),
    .rd_addr(rd_addr), .rd_en_n(rd_en_b_n), .rd_q(rd_q_b), .rd_oe(rd_oe_b));

  wire [3:0] bus = rd_q | rd_q_b;

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en_n = 1'b0;
    @(negedge clk);
    wr_en_n = 1'b1;
    model[a] = d;
  endtask

  task automatic rd_chk(string req, logic [1:0] a);
    @(negedge clk);
    rd_addr = a; rd_en_n = 1'b0;
    #1;
    chk(req, rd_q, model[a]);
    chk(req, {3'b0, rd_oe}, 4'h1);
  endtask

  task automatic t_idle();
    @(negedge clk); #1;
    chk("R4 idle oe", {3'b0, rd_oe}, 4'h0);
    chk("R4 idle q", rd_q, 4'h0);
  endtask

  task automatic t_fill();
    wr(0, 4'h3); wr(1, 4'hC); wr(2, 4'h5); wr(3, 4'hA);
    for (int i = 0; i < 4; i++) rd_chk("R1 R5 fill", 2'(i));
    wr(2, 4'hF);
    for (int i = 0; i < 4; i++) rd_chk("R1 one word changes", 2'(i));
  endtask

  task automatic t_hold();
    @(negedge clk);
    wr_en_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      wr_addr = 2'(i); wr_data = ~model[i];
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) rd_chk("R2 hold", 2'(i));
  endtask

  task automatic t_disable();
    @(negedge clk);
    rd_en_n = 1'b1; rd_addr = 2'd1; #1;
    chk("R4 disabled q", rd_q, 4'h0);
    chk("R4 disabled oe", {3'b0, rd_oe}, 4'h0);
  endtask

  task automatic t_transparent();
    @(negedge clk);
    rd_addr = 2'd2; rd_en_n = 1'b0; wr_addr = 2'd2; wr_data = 4'h1; wr_en_n = 1'b0;
    #1; chk("R8 write-through a", rd_q, 4'h1);
    wr_data = 4'h6; #1; chk("R3 R8 follows b", rd_q, 4'h6);
    wr_data = 4'h9; #1; chk("R3 R8 follows c", rd_q, 4'h9);
    @(negedge clk);
    wr_en_n = 1'b1; #1;
    wr_data = 4'h0; #1;
    chk("R3 last value kept", rd_q, 4'h9);
    model[2] = 4'h9;
  endtask

  task automatic t_simul();
    @(negedge clk);
    rd_addr = 2'd3; rd_en_n = 1'b0;
    wr_addr = 2'd1; wr_data = 4'h7; wr_en_n = 1'b0; #1;
    chk("R6 read other word", rd_q, model[3]);
    @(negedge clk);
    wr_en_n = 1'b1; model[1] = 4'h7;
    rd_chk("R6 written word", 2'd1);
  endtask

  task automatic t_nondestructive();
    for (int i = 0; i < 3; i++) rd_chk("R7 repeat read", 2'd0);
  endtask

  task automatic t_expand();
    @(negedge clk);
    rd_en_n = 1'b1;
    wr_addr = 2'd0; wr_data = 4'hE; wr_en_b_n = 1'b0;
    @(negedge clk);
    wr_en_b_n = 1'b1;
    @(negedge clk);
    rd_addr = 2'd0; rd_en_b_n = 1'b0; #1;
    chk("R9 one oe (b)", 4'(rd_oe + rd_oe_b), 4'h1);
    chk("R9 bus from b", bus, 4'hE);
    @(negedge clk);
    rd_en_b_n = 1'b1; rd_en_n = 1'b0; #1;
    chk("R9 one oe (a)", 4'(rd_oe + rd_oe_b), 4'h1);
    chk("R9 bus from a", bus, model[0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_idle();
    t_fill();
    t_hold();
    t_disable();
    t_transparent();
    t_simul();
    t_nondestructive();
    t_expand();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 4'h1, 4'h0);
    finish_run();
  end
endmodule